// File: doc/BRIEF.md
# Saturating Shift and Precision-Reduction Unit

This block shifts a packed operand word lane by lane and narrows fixed-point values. Left shifts detect when significant bits are pushed out. They either wrap or clamp to the lane's most positive or most negative value. Rounding arithmetic right shifts divide each lane by a power of two and round half up. Two narrowing operations are also provided. One rounds a signed 32-bit value down to its upper 16 bits. The other converts a signed 16-bit value into an unsigned 8-bit one.

The operand is split into 8-, 16- or 32-bit lanes. Every lane uses the same shift amount. An operation is taken on a clock edge while the strobe is high, and its result appears on the following cycle. Any overflow during such an operation sets a sticky status bit, which only reset clears.

Top module: `sat_shift_unit`

## Requirements
- R1: While reset is low, `result_o` and `flag_o` are both 0.
- R2: Lane select 0 gives four 8-bit lanes using amount bits [2:0]. Lane select 1 gives two 16-bit lanes using bits [3:0]. Values 2 and 3 give one 32-bit lane using bits [4:0]. All lanes use the same amount.
- R3: For ops 0, 1 and 2, a masked shift amount of zero returns the operand unchanged and leaves the flag untouched.
- R4: Op 0 is a wrapping left shift. A lane overflows when its top s+1 bits are not all equal to its sign bit. Overflow sets the flag, and the result is the lane shifted left with the upper bits discarded.
- R5: Op 1 is a saturating left shift. An overflowing lane returns the lane maximum (0x7F, 0x7FFF or 0x7FFFFFFF) if the operand is non-negative, and the lane minimum (0x80, 0x8000 or 0x80000000) if it is negative. The flag is set. A lane that does not overflow gives the plain shifted value.
- R6: Op 2 is a rounding arithmetic right shift. For s > 0 each lane becomes ((x >>> (s-1)) + 1) >>> 1. This operation never sets the flag.
- R7: Op 3 is rounding truncation of the signed 32-bit operand. The result is bits [31:16] of (x + 0x8000), returned in `result_o[15:0]`. An operand at or above 0x7FFF8000 returns 0x7FFF and sets the flag. The upper result bits are 0.
- R8: Op 4 reduces `data_i[15:0]` to 8 bits. A non-negative input returns bits [14:7]. A magnitude above 0x7F80 returns 0xFF and sets the flag. A negative input returns 0x00 and sets the flag. Operand bits above 15 are ignored, and result bits above 7 are 0.
- R9: Op codes 5 to 7 return 0 and never set the flag.
- R10: `result_o` and `flag_o` change only on a clock edge where `op_valid_i` is high, one cycle after the operation is applied. `flag_o` is the OR of all lane overflows, accumulated stickily.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_valid_i | input | 1 | Operation strobe |
| op_i | input | 3 | Operation code (0 wrap shl, 1 sat shl, 2 round shr, 3 truncate, 4 reduce) |
| lane_i | input | 2 | Lane size select (0: 8, 1: 16, 2/3: 32 bits) |
| amt_i | input | 5 | Shift amount, masked to lane size |
| data_i | input | DATA_W | Operand word |
| result_o | output | DATA_W | Registered result |
| flag_o | output | 1 | Sticky overflow status |

## Verification
Two things can meet in one cycle: the data path's clamping of a lane and the sticky flag's accumulation from another lane. The bench provokes this with packed operands where one lane overflows and its neighbour shifts cleanly. Examples are 16-bit lanes 0x0800 and 0xF800 shifted by 4, and a 32-bit shift by 31 of -1 against one of +1. Every cycle, the behavioural model's prediction of both the result word and the flag is compared with the design. A wrong lane merge or a missed OR therefore shows up on the same edge.

// File: rtl/sat_shift_pkg.sv
package sat_shift_pkg;
  localparam int AMT_W = 5;

  typedef enum logic [2:0] {
    OP_SHL     = 3'd0,
    OP_SHL_SAT = 3'd1,
    OP_RSHR    = 3'd2,
    OP_TRUNC   = 3'd3,
    OP_REDUCE  = 3'd4
  } ss_op_e;

  typedef enum logic [1:0] {
    LANE_B = 2'd0,
    LANE_H = 2'd1,
    LANE_W = 2'd2
  } ss_lane_e;
endpackage

// File: rtl/sat_shift_lane.sv
module sat_shift_lane #(
  parameter int W = 8
) (
  input  logic [W-1:0]         x_i,
  input  logic [$clog2(W)-1:0] s_i,
  input  logic                 sat_i,
  output logic [W-1:0]         shl_o,
  output logic [W-1:0]         shr_o,
  output logic                 ovf_o
);
  localparam int SW = $clog2(W);
  localparam logic [SW-1:0] MSB_IDX = SW'(W - 1);

  logic [SW-1:0] keep_sh, s_m1;
  logic [W-1:0]  top;
  logic [W:0]    ext, rnd;

  // bits that survive plus the new sign must all match the old sign
  assign keep_sh = MSB_IDX - s_i;
  assign top     = $signed(x_i) >>> keep_sh;
  assign ovf_o   = ~((&top) | ~(|top));

  always_comb begin
    shl_o = x_i << s_i;
    if (sat_i && ovf_o)
      shl_o = x_i[W-1] ? {1'b1, {(W-1){1'b0}}} : {1'b0, {(W-1){1'b1}}};
  end

  // round: shift by s-1 in W+1 bits, add one, drop the last bit
  assign s_m1  = s_i - SW'(1);
  assign ext   = $signed({x_i[W-1], x_i}) >>> s_m1;
  assign rnd   = ext + (W+1)'(1);
  assign shr_o = (s_i == '0) ? x_i : rnd[W:1];
endmodule

// File: rtl/sat_shift_narrow.sv
module sat_shift_narrow (
  input  logic [31:0] d_i,
  output logic [15:0] trunc_o,
  output logic        trunc_ovf_o,
  output logic [7:0]  red_o,
  output logic        red_ovf_o
);
  logic [31:0] sum;

  assign sum         = d_i + 32'h0000_8000;
  assign trunc_ovf_o = $signed(d_i) >= $signed(32'h7FFF_8000);
  assign trunc_o     = trunc_ovf_o ? 16'h7FFF : sum[31:16];

  always_comb begin
    red_ovf_o = 1'b0;
    red_o     = d_i[14:7];
    if (d_i[15]) begin
      red_o     = 8'h00;
      red_ovf_o = 1'b1;
    end else if (d_i[14:0] > 15'h7F80) begin
      red_o     = 8'hFF;
      red_ovf_o = 1'b1;
    end
  end
endmodule

// File: rtl/sat_shift_unit.sv
module sat_shift_unit
  import sat_shift_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              op_valid_i,
  input  logic [2:0]        op_i,
  input  logic [1:0]        lane_i,
  input  logic [AMT_W-1:0]  amt_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] result_o,
  output logic              flag_o
);
  localparam int NB = DATA_W / 8;
  localparam int NH = DATA_W / 16;
  localparam int NW = DATA_W / 32;

  logic              sat;
  logic [DATA_W-1:0] b_shl, b_shr, h_shl, h_shr, w_shl, w_shr;
  logic [NB-1:0]     b_ovf;
  logic [NH-1:0]     h_ovf;
  logic [NW-1:0]     w_ovf;
  logic [DATA_W-1:0] sel_shl, sel_shr, next_res;
  logic              sel_ovf, next_ovf;
  logic [15:0]       trunc;
  logic [7:0]        red;
  logic              trunc_ovf, red_ovf;

  assign sat = (op_i == OP_SHL_SAT);

  for (genvar g = 0; g < NB; g++) begin : g_b
    sat_shift_lane #(.W(8)) u_lane (
      .x_i(data_i[g*8 +: 8]), .s_i(amt_i[2:0]), .sat_i(sat),
      .shl_o(b_shl[g*8 +: 8]), .shr_o(b_shr[g*8 +: 8]), .ovf_o(b_ovf[g]));
  end
  for (genvar g = 0; g < NH; g++) begin : g_h
    sat_shift_lane #(.W(16)) u_lane (
      .x_i(data_i[g*16 +: 16]), .s_i(amt_i[3:0]), .sat_i(sat),
      .shl_o(h_shl[g*16 +: 16]), .shr_o(h_shr[g*16 +: 16]), .ovf_o(h_ovf[g]));
  end
  for (genvar g = 0; g < NW; g++) begin : g_w
    sat_shift_lane #(.W(32)) u_lane (
      .x_i(data_i[g*32 +: 32]), .s_i(amt_i[4:0]), .sat_i(sat),
      .shl_o(w_shl[g*32 +: 32]), .shr_o(w_shr[g*32 +: 32]), .ovf_o(w_ovf[g]));
  end

  sat_shift_narrow u_narrow (
    .d_i(data_i[31:0]), .trunc_o(trunc), .trunc_ovf_o(trunc_ovf),
    .red_o(red), .red_ovf_o(red_ovf));

  always_comb begin
    case (lane_i)
      LANE_B:  begin sel_shl = b_shl; sel_shr = b_shr; sel_ovf = |b_ovf; end
      LANE_H:  begin sel_shl = h_shl; sel_shr = h_shr; sel_ovf = |h_ovf; end
      default: begin sel_shl = w_shl; sel_shr = w_shr; sel_ovf = |w_ovf; end
    endcase
  end

  always_comb begin
    next_res = '0;
    next_ovf = 1'b0;
    case (op_i)
      OP_SHL, OP_SHL_SAT: begin next_res = sel_shl; next_ovf = sel_ovf; end
      OP_RSHR:            next_res = sel_shr;
      OP_TRUNC:  begin next_res = {{(DATA_W-16){1'b0}}, trunc}; next_ovf = trunc_ovf; end
      OP_REDUCE: begin next_res = {{(DATA_W-8){1'b0}}, red};    next_ovf = red_ovf;   end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o <= '0;
      flag_o   <= 1'b0;
    end else if (op_valid_i) begin
      result_o <= next_res;
      flag_o   <= flag_o | next_ovf;
    end
  end
endmodule

// File: rtl/sat_shift_chk.sv
module sat_shift_chk
  import sat_shift_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              op_valid_i,
  input logic [2:0]        op_i,
  input logic [1:0]        lane_i,
  input logic [AMT_W-1:0]  amt_i,
  input logic [DATA_W-1:0] data_i,
  input logic [DATA_W-1:0] result_o,
  input logic              flag_o
);
  // R10
  result_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !op_valid_i |=> $stable(result_o));

  // R10
  flag_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_o |=> flag_o);

  // R10
  flag_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_o) |-> $past(op_valid_i));

  // R6
  rshr_no_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && op_i == OP_RSHR) |=> (flag_o == $past(flag_o)));

  // R3
  zero_amt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && op_i <= OP_RSHR && amt_i == '0) |=> (result_o == $past(data_i)));

  // R8
  reduce_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && op_i == OP_REDUCE) |=> (result_o[DATA_W-1:8] == '0));

  // R9
  bad_op_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && op_i > OP_REDUCE) |=> (result_o == '0 && flag_o == $past(flag_o)));

  // R2
  lane_known_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_valid_i |-> !$isunknown(lane_i));
endmodule

bind sat_shift_unit sat_shift_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .op_valid_i(op_valid_i), .op_i(op_i),
  .lane_i(lane_i), .amt_i(amt_i), .data_i(data_i), .result_o(result_o),
  .flag_o(flag_o));

// File: tb/tb_sat_shift_unit.sv
module tb_sat_shift_unit;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        op_valid = 1'b0;
  logic [2:0]  op = '0;
  logic [1:0]  lane = '0;
  logic [4:0]  amt = '0;
  logic [31:0] data = '0;
  logic [31:0] result;
  logic        flag;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  logic [31:0] exp_res = '0;
  bit          exp_flag = 0;
  string       exp_req = "R1";

  always #(CLK_P/2) clk = ~clk;

  sat_shift_unit dut (
    .clk_i(clk), .rst_ni(rst_ni), .op_valid_i(op_valid), .op_i(op),
    .lane_i(lane), .amt_i(amt), .data_i(data), .result_o(result), .flag_o(flag));

  // behavioural reference of one operation
  function automatic void ref_op(input logic [2:0] o, input logic [1:0] ln,
                                 input logic [4:0] a, input logic [31:0] d,
                                 output logic [31:0] r, output bit ov);
    int w, n, s;
    longint u, x, y, lim, msk;
    r = '0; ov = 0;
    w = (ln == 2'd0) ? 8 : (ln == 2'd1) ? 16 : 32;
    n = 32 / w;
    s = int'(a) % w;
    msk = (longint'(1) << w) - 1;
    lim = longint'(1) << (w - 1);
    case (o)
      3'd0, 3'd1, 3'd2: begin
        for (int i = 0; i < n; i++) begin
          u = longint'(d >> (i*w)) & msk;
          x = (u >= lim) ? u - (longint'(1) << w) : u;
          if (o == 3'd2) begin
            y = (s == 0) ? x : (((x >>> (s-1)) + 1) >>> 1);
          end else begin
            y = x <<< s;
            if (y >= lim || y < -lim) begin
              ov = 1;
              if (o == 3'd1) y = (x < 0) ? -lim : lim - 1;
            end
          end
          r = r | 32'((y & msk) << (i*w));
        end
      end
      3'd3: begin
        x = longint'($signed(d));
        if (x >= 64'sh7FFF8000) begin r = 32'h7FFF; ov = 1; end
        else r = 32'(((x + 32768) >>> 16) & 64'hFFFF);
      end
      3'd4: begin
        if (d[15]) begin r = '0; ov = 1; end
        else if (d[14:0] > 15'h7F80) begin r = 32'hFF; ov = 1; end
        else r = {24'b0, d[14:7]};
      end
      default: r = '0;
    endcase
  endfunction

  function automatic string req_of(input logic [2:0] o, input logic [1:0] ln, input logic [4:0] a);
    int s;
    s = int'(a) % ((ln == 2'd0) ? 8 : (ln == 2'd1) ? 16 : 32);
    if (o <= 3'd2 && s == 0) return "R3";
    case (o)
      3'd0: return "R4";
      3'd1: return "R5";
      3'd2: return "R6";
      3'd3: return "R7";
      3'd4: return "R8";
      default: return "R9";
    endcase
  endfunction

  // model advances on the same edges as the design
  always @(posedge clk or negedge rst_ni) begin
    logic [31:0] m_r;
    bit m_ov;
    if (!rst_ni) begin
      exp_res  <= '0;
      exp_flag <= 0;
    end else if (op_valid) begin
      ref_op(op, lane, amt, data, m_r, m_ov);
      exp_res  <= m_r;
      exp_flag <= exp_flag | m_ov;
      exp_req  <= req_of(op, lane, amt);
    end
  end

  // compare every cycle, away from the rising edge; R2 lane tag in message
  always @(negedge clk) begin
    if (rst_ni && !done) begin
      n_chk++;
      if (result !== exp_res) begin
        n_fail++;
        $display("FAIL %s (R2 lane=%0d) result actual=%h expected=%h", exp_req, lane, result, exp_res);
      end
      n_chk++;
      if (flag !== exp_flag) begin
        n_fail++;
        $display("FAIL R10 flag actual=%0b expected=%0b (last %s)", flag, exp_flag, exp_req);
      end
    end
  end

  task automatic apply(input logic [2:0] o, input logic [1:0] ln, input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    op = o; lane = ln; amt = a; data = d; op_valid = 1'b1;
    @(negedge clk);
    op_valid = 1'b0;
    data = ~d;
  endtask

  task automatic pulse_reset();
    @(negedge clk);
    rst_ni = 1'b0;
    @(negedge clk);
    rst_ni = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1
    n_chk++;
    if (result !== 32'h0 || flag !== 1'b0) begin
      n_fail++;
      $display("FAIL R1 reset actual=%h/%0b expected=00000000/0", result, flag);
    end
    rst_ni = 1'b1;

    apply(3'd0, 2'd0, 5'd0,  32'h80FF_7F01);   // R3
    apply(3'd0, 2'd0, 5'd1,  32'h203F_E0C0);   // R4 no overflow
    apply(3'd0, 2'd0, 5'd1,  32'h4040_4040);   // R4 overflow
    pulse_reset();
    apply(3'd1, 2'd1, 5'd4,  32'h0800_F800);   // R5 one lane clamps, one fits
    pulse_reset();
    apply(3'd1, 2'd2, 5'd31, 32'hFFFF_FFFF);   // R5 exact minimum, no overflow
    apply(3'd1, 2'd2, 5'd31, 32'h0000_0001);   // R5 clamp to max
    pulse_reset();
    apply(3'd1, 2'd1, 5'b10011, 32'h1000_EFFF);// R2 masking to 3
    apply(3'd1, 2'd3, 5'd8,  32'h8000_0000);   // R2 lane 3 as 32-bit
    pulse_reset();
    apply(3'd2, 2'd0, 5'd1,  32'h7F80_0103);   // R6
    apply(3'd2, 2'd2, 5'd31, 32'h8000_0000);   // R6
    apply(3'd2, 2'd1, 5'd16, 32'h8001_7FFF);   // R3 masked to zero
    apply(3'd3, 2'd0, 5'd0,  32'h7FFF_7FFF);   // R7
    apply(3'd3, 2'd0, 5'd0,  32'h8000_0000);   // R7
    apply(3'd3, 2'd0, 5'd0,  32'h0001_8000);   // R7
    apply(3'd3, 2'd0, 5'd0,  32'h7FFF_8000);   // R7 boundary
    pulse_reset();
    apply(3'd4, 2'd0, 5'd0,  32'hABCD_7F80);   // R8 boundary, upper ignored
    apply(3'd4, 2'd0, 5'd0,  32'h0000_1234);   // R8
    apply(3'd4, 2'd0, 5'd0,  32'h0000_7F81);   // R8 clamp
    pulse_reset();
    apply(3'd4, 2'd0, 5'd0,  32'h0000_8000);   // R8 negative
    pulse_reset();
    for (int k = 5; k < 8; k++) apply(3'(k), 2'd2, 5'd3, 32'hFFFF_0001); // R9

    for (int i = 0; i < 3000; i++) begin
      logic [31:0] d;
      d = $urandom;
      case (i % 4)
        1: d = d & 32'h8181_8181;
        2: d = d | 32'h7F00_7F00;
        default: ;
      endcase
      if (i % 48 == 0) pulse_reset();
      apply(3'($urandom % 8), 2'($urandom), 5'($urandom), d);
    end

    repeat (2) @(negedge clk);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule